// File: doc/BRIEF.md
# Shared Interrupt Sense and Routing Unit

This block takes a parameterised group of external interrupt lines, a multiple of eight, and conditions each one. A line can be level sensitive with either polarity, sensitive to one edge (rising or falling), or sensitive to both edges. Every line passes through a two-flop synchroniser. Edge detection compares the synchronised sample with the sample one cycle older. An edge event sets a sticky pending bit, and a level line's pending bit tracks the corrected input.

Software configures the block over a simple 32-bit register bus. The bus has write-one-only set and clear ports for the enable mask. It also has a single wedge register that injects or acknowledges edge events by source number, and one routing register per source that names exactly one processor context. For every context the block drives a request line and the index of the lowest-numbered source that is pending, enabled and routed to that context. The interrupt handler reads the index, services that source, and acknowledges it through the wedge register.

Word address map (10-bit word address): when `bus_addr[9:8]` = 0, `bus_addr[7:4]` selects a bank and `bus_addr[3:0]` selects a 32-source word within it. Bank 0 is configuration, 1 polarity, 2 trigger, 3 dual edge, 4 mask set, 5 mask clear, 6 mask readback, 7 pending readback and 8 wedge. When `bus_addr[9:8]` = 1, `bus_addr[7:0]` selects the routing register of that source.

Top module: `shirq_router`

## Requirements
- R1: A read of bank 0 word 0 returns SRC/8-1 in bits [7:0] and NUM_CTX-1 in bits [15:8], with every other bit 0.
- R2: After reset every source reads polarity 1 (active high / rising), trigger 0 (level) and dual 0. The mask reads all zero, every routing register reads 1 (context 0), and all request lines are low.
- R3: A level source's pending bit is its synchronised input XNOR its polarity bit. A change on the input shows at the pending readback and outputs after the second rising clock edge and not after the first.
- R4: With trigger 1 and dual 0, a transition in the direction given by polarity (1 rising, 0 falling) sets pending after the third rising clock edge. A transition in the opposite direction sets nothing.
- R5: With trigger 1 and dual 1, both rising and falling transitions set pending, whatever the polarity.
- R6: A write to the mask set bank sets the enable of each source whose data bit is 1. A write to the mask clear bank clears those enables. Data bits at 0 leave the enable unchanged.
- R7: A wedge write with bit 31 = 1 sets the pending bit of the edge source numbered by bits [7:0]. The same write with bit 31 = 0 clears it. A source number of SRC or above has no effect. An edge-latched pending bit stays set until cleared this way, even after the input returns.
- R8: The wedge register has no effect on a level source: it neither sets nor clears its pending bit.
- R9: A routing write selects the lowest set bit among data bits [NUM_CTX-1:0] as the sole context of that source. A write with those bits all zero leaves the route unchanged. The readback is one-hot.
- R10: For each context c, `ctx_irq[c]` is 1 when some source is pending, enabled and routed to c. `ctx_idx` field c then holds the lowest such source number, and holds 0 when none exists.
- R11: A disabled source still shows in the pending readback but raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | SRC | Raw external interrupt lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ctx_irq | output | NUM_CTX | Request per context |
| ctx_idx | output | NUM_CTX*IDX_W | Lowest eligible source per context, field c at [c*IDX_W +: IDX_W] |

## Verification
A corrupted edge latch appears in the pending readback after the cycle in which it was written. It also moves the index of the owning context at the same moment, and it persists until a wedge clear. A wrong synchroniser or edge-compare stage changes the latency of a pending bit, so the sweep samples one edge early as well as on time. A broken route or mask moves a request to the wrong context, or drops it, one cycle after the write. The priority checks clear the sources one by one and compare every context's index after each step.

// File: rtl/shirq_pkg.sv
package shirq_pkg;

  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 10;
  localparam int WEDGE_SET = 31;

  typedef enum logic [3:0] {
    RG_CONFIG = 4'h0,
    RG_POL    = 4'h1,
    RG_TRIG   = 4'h2,
    RG_DUAL   = 4'h3,
    RG_MSET   = 4'h4,
    RG_MCLR   = 4'h5,
    RG_MASK   = 4'h6,
    RG_PEND   = 4'h7,
    RG_WEDGE  = 4'h8
  } bank_e;

  // true when source number src lives in 32-bit word 'word'
  function automatic logic word_match(int src, logic [3:0] word);
    return (src / BUS_W) == int'(word);
  endfunction

  // isolate the lowest set bit of a word
  function automatic logic [BUS_W-1:0] lowest_onehot(logic [BUS_W-1:0] v);
    return v & (~v + 32'd1);
  endfunction

endpackage

// File: rtl/shirq_sense.sv
module shirq_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic pol_i,
  input  logic trig_i,
  input  logic dual_i,
  input  logic wset_i,
  input  logic wclr_i,
  output logic pend_o
);
  logic s1_q, s2_q, s3_q, latch_q;
  logic rise_w, fall_w, edge_hit_w, latch_d, level_active_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      s3_q    <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      s1_q    <= raw_i;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      latch_q <= latch_d;
    end
  end

  assign rise_w         = s2_q & ~s3_q;
  assign fall_w         = ~s2_q & s3_q;
  assign edge_hit_w     = dual_i ? (rise_w | fall_w) : (pol_i ? rise_w : fall_w);
  assign latch_d        = trig_i ? (edge_hit_w | wset_i | (latch_q & ~wclr_i)) : 1'b0;
  assign level_active_w = pol_i ? s2_q : ~s2_q;
  assign pend_o         = trig_i ? latch_q : level_active_w;

  // R8: a level source never keeps an edge latch
  assert_level_no_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_i |=> !latch_q);
  // R5: either transition latches in dual mode
  assert_dual_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && dual_i && (rise_w || fall_w)) |=> latch_q);
  // R7: wedge set on an edge source latches
  assert_wedge_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && wset_i) |=> latch_q);
  // R7: latched edge holds until cleared
  assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && latch_q && !wclr_i) |=> latch_q);

endmodule

// File: rtl/shirq_pick.sv
module shirq_pick #(
  parameter int SRC   = 16,
  parameter int IDX_W = $clog2(SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC-1:0]   elig_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [SRC-1:0] below_w;

  always_comb begin
    idx_o = '0;
    for (int i = SRC - 1; i >= 0; i--) begin
      if (elig_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign irq_o   = |elig_i;
  assign below_w = (SRC'(1) << idx_o) - SRC'(1);

  // R10: the chosen source is eligible and nothing below it is
  assert_pick_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (elig_i[idx_o] && ((elig_i & below_w) == '0)));
  assert_idle_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (idx_o == '0));

endmodule

// File: rtl/shirq_router.sv
module shirq_router #(
  parameter int GROUPS  = 2,
  parameter int NUM_CTX = 4,
  localparam int SRC    = GROUPS * 8,
  localparam int IDX_W  = $clog2(SRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SRC-1:0]           src_in,
  input  logic                     bus_we,
  input  logic [9:0]               bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic [NUM_CTX-1:0]       ctx_irq,
  output logic [NUM_CTX*IDX_W-1:0] ctx_idx
);
  import shirq_pkg::*;

  logic [1:0]  page_w;
  bank_e       bank_w;
  logic [3:0]  word_w;
  logic [7:0]  src_sel_w;
  logic        wr_reg_w, wr_route_w, wedge_wr_w;
  logic [NUM_CTX-1:0] route_pick_w;

  logic [SRC-1:0] pol_q, trig_q, dual_q, mask_q;
  logic [NUM_CTX-1:0] route_q [SRC];
  logic [SRC-1:0] wset_w, wclr_w, pend_w, bank_view_w;

  assign page_w       = bus_addr[9:8];
  assign bank_w       = bank_e'(bus_addr[7:4]);
  assign word_w       = bus_addr[3:0];
  assign src_sel_w    = bus_addr[7:0];
  assign wr_reg_w     = bus_we && (page_w == 2'd0);
  assign wr_route_w   = bus_we && (page_w == 2'd1);
  assign wedge_wr_w   = wr_reg_w && (bank_w == RG_WEDGE) && (word_w == 4'd0);
  assign route_pick_w = NUM_CTX'(lowest_onehot(32'(bus_wdata[NUM_CTX-1:0])));

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '1;
      trig_q <= '0;
      dual_q <= '0;
      mask_q <= '0;
      for (int i = 0; i < SRC; i++) route_q[i] <= NUM_CTX'(1);
    end else begin
      for (int i = 0; i < SRC; i++) begin
        if (wr_reg_w && word_match(i, word_w)) begin
          case (bank_w)
            RG_POL:  pol_q[i]  <= bus_wdata[i % 32];
            RG_TRIG: trig_q[i] <= bus_wdata[i % 32];
            RG_DUAL: dual_q[i] <= bus_wdata[i % 32];
            RG_MSET: if (bus_wdata[i % 32]) mask_q[i] <= 1'b1;
            RG_MCLR: if (bus_wdata[i % 32]) mask_q[i] <= 1'b0;
            default: ;
          endcase
        end
        if (wr_route_w && (int'(src_sel_w) == i) && (route_pick_w != '0))
          route_q[i] <= route_pick_w;
      end
    end
  end

  // wedge decode
  always_comb begin
    for (int i = 0; i < SRC; i++) begin
      wset_w[i] = wedge_wr_w &&  bus_wdata[WEDGE_SET] && (bus_wdata[7:0] == 8'(i));
      wclr_w[i] = wedge_wr_w && !bus_wdata[WEDGE_SET] && (bus_wdata[7:0] == 8'(i));
    end
  end

  // per-source sense
  for (genvar g = 0; g < SRC; g++) begin : g_src
    shirq_sense u_sense (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (src_in[g]),
      .pol_i  (pol_q[g]),
      .trig_i (trig_q[g]),
      .dual_i (dual_q[g]),
      .wset_i (wset_w[g]),
      .wclr_i (wclr_w[g]),
      .pend_o (pend_w[g])
    );
    // R9: every source has exactly one context
    assert_route_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(route_q[g]) == 1);
  end

  // per-context selection
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic [SRC-1:0] elig_w;
    always_comb begin
      for (int i = 0; i < SRC; i++) elig_w[i] = pend_w[i] & mask_q[i] & route_q[i][c];
    end
    shirq_pick #(.SRC(SRC), .IDX_W(IDX_W)) u_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .elig_i (elig_w),
      .irq_o  (ctx_irq[c]),
      .idx_o  (ctx_idx[c*IDX_W +: IDX_W])
    );
    // R11: a request needs an enabled pending source
    assert_irq_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_irq[c] |-> ((mask_q & pend_w) != '0));
  end

  // read path
  always_comb begin
    case (bank_w)
      RG_POL:  bank_view_w = pol_q;
      RG_TRIG: bank_view_w = trig_q;
      RG_DUAL: bank_view_w = dual_q;
      RG_MASK: bank_view_w = mask_q;
      RG_PEND: bank_view_w = pend_w;
      default: bank_view_w = '0;
    endcase
    bus_rdata = '0;
    if (page_w == 2'd1) begin
      for (int i = 0; i < SRC; i++)
        if (int'(src_sel_w) == i) bus_rdata = 32'(route_q[i]);
    end else if (page_w == 2'd0) begin
      if (bank_w == RG_CONFIG) begin
        if (word_w == 4'd0) bus_rdata = {16'h0, 8'(NUM_CTX - 1), 8'(GROUPS - 1)};
      end else begin
        for (int i = 0; i < SRC; i++)
          if (word_match(i, word_w)) bus_rdata[i % 32] = bank_view_w[i];
      end
    end
  end

  // R6: mask strobes take effect on the next cycle (source 0)
  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg_w && bank_w == RG_MSET && word_w == 4'd0 && bus_wdata[0]) |=> mask_q[0]);
  assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg_w && bank_w == RG_MCLR && word_w == 4'd0 && bus_wdata[0]) |=> !mask_q[0]);

endmodule

// File: tb/shirq_router_test.sv
module shirq_router_test;
  localparam int SRC = 16;
  localparam int NC  = 4;
  localparam int IW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SRC-1:0] src = '0;
  logic bus_we = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] ctx_irq;
  logic [NC*IW-1:0] ctx_idx;

  int checks = 0;
  int fails = 0;
  logic [15:0] exp_pend = '0;
  logic [15:0] exp_mask = '0;
  int exp_route [SRC];

  always #2 clk = ~clk;

  shirq_router uut (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctx_irq(ctx_irq), .ctx_idx(ctx_idx)
  );

  localparam logic [9:0] A_CFG = 10'h000, A_POL = 10'h010, A_TRIG = 10'h020,
    A_DUAL = 10'h030, A_MSET = 10'h040, A_MCLR = 10'h050, A_MASK = 10'h060,
    A_PEND = 10'h070, A_WEDGE = 10'h080, A_ROUTE = 10'h100;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [9:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic ctx_check(input string req);
    for (int c = 0; c < NC; c++) begin
      logic eirq;
      logic [IW-1:0] eidx;
      eirq = 1'b0; eidx = '0;
      for (int i = SRC - 1; i >= 0; i--)
        if (exp_pend[i] && exp_mask[i] && exp_route[i] == c) begin
          eirq = 1'b1; eidx = IW'(i);
        end
      check(req, {27'h0, ctx_irq[c], ctx_idx[c*IW +: IW]}, {27'h0, eirq, eidx});
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < SRC; i++) exp_route[i] = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 / R2: reset state and configuration word
    rd_check("R1", A_CFG, 32'h0000_0301);
    rd_check("R2", A_POL, 32'h0000_FFFF);
    rd_check("R2", A_TRIG, 32'h0);
    rd_check("R2", A_DUAL, 32'h0);
    rd_check("R2", A_MASK, 32'h0);
    for (int i = 0; i < SRC; i++) rd_check("R2", A_ROUTE + 10'(i), 32'h1);
    check("R2", 32'(ctx_irq), 32'h0);

    // R6: set/clear strobes
    wr(A_MSET, 32'h00F0); rd_check("R6", A_MASK, 32'h00F0);
    wr(A_MSET, 32'h0);    rd_check("R6", A_MASK, 32'h00F0);
    wr(A_MCLR, 32'h0030); rd_check("R6", A_MASK, 32'h00C0);
    wr(A_MCLR, 32'h0);    rd_check("R6", A_MASK, 32'h00C0);
    wr(A_MSET, 32'hFFFF); rd_check("R6", A_MASK, 32'hFFFF);
    exp_mask = 16'hFFFF;

    // R3: level, active high, with latency
    for (int i = 0; i < SRC; i++) begin
      src = 16'(1) << i;
      tick(1); rd_check("R3", A_PEND, 32'h0);
      tick(1); rd_check("R3", A_PEND, 32'(src));
      exp_pend = src; ctx_check("R3");
      src = '0; tick(2);
    end
    exp_pend = '0;
    // R3: level, active low
    wr(A_POL, 32'h0);
    rd_check("R3", A_PEND, 32'hFFFF);
    exp_pend = 16'hFFFF; ctx_check("R3");
    for (int i = 0; i < SRC; i++) begin
      src = ~(16'(1) << i);
      tick(2); rd_check("R3", A_PEND, 32'(16'(1) << i));
      exp_pend = 16'(1) << i; ctx_check("R3");
    end
    src = '0; tick(2);
    wr(A_POL, 32'hFFFF);
    exp_pend = '0;

    // R4: rising edge
    wr(A_TRIG, 32'hFFFF);
    rd_check("R4", A_PEND, 32'h0);
    for (int i = 0; i < SRC; i++) begin
      src = 16'(1) << i;
      tick(2); rd_check("R4", A_PEND, 32'h0);
      tick(1); rd_check("R4", A_PEND, 32'(16'(1) << i));
      exp_pend = 16'(1) << i; ctx_check("R4");
      src = '0; tick(3);
      rd_check("R7", A_PEND, 32'(16'(1) << i));
      wr(A_WEDGE, 32'(i)); rd_check("R7", A_PEND, 32'h0);
    end
    // R4: falling edge
    wr(A_POL, 32'h0);
    for (int i = 0; i < SRC; i++) begin
      src = 16'(1) << i; tick(3); rd_check("R4", A_PEND, 32'h0);
      src = '0;          tick(3); rd_check("R4", A_PEND, 32'(16'(1) << i));
      wr(A_WEDGE, 32'(i)); rd_check("R7", A_PEND, 32'h0);
    end

    // R5: dual edge, polarity ignored
    wr(A_DUAL, 32'hFFFF);
    wr(A_POL, 32'hAAAA);
    for (int i = 0; i < SRC; i++) begin
      src = 16'(1) << i; tick(3); rd_check("R5", A_PEND, 32'(16'(1) << i));
      wr(A_WEDGE, 32'(i));
      src = '0; tick(3); rd_check("R5", A_PEND, 32'(16'(1) << i));
      wr(A_WEDGE, 32'(i)); rd_check("R5", A_PEND, 32'h0);
    end

    // R7: wedge set and clear by number
    exp_pend = '0;
    for (int i = 0; i < SRC; i++) begin
      wr(A_WEDGE, 32'h8000_0000 | 32'(i));
      rd_check("R7", A_PEND, 32'(16'(1) << i));
      exp_pend = 16'(1) << i; ctx_check("R7");
      wr(A_WEDGE, 32'(i)); rd_check("R7", A_PEND, 32'h0);
    end
    exp_pend = '0;
    wr(A_WEDGE, 32'h8000_0020); rd_check("R7", A_PEND, 32'h0);

    // R8: wedge ignored on level sources
    wr(A_TRIG, 32'h0); wr(A_DUAL, 32'h0); wr(A_POL, 32'hFFFF);
    wr(A_WEDGE, 32'h8000_0005); tick(1); rd_check("R8", A_PEND, 32'h0);
    src = 16'h0020; tick(2); rd_check("R8", A_PEND, 32'h0020);
    wr(A_WEDGE, 32'h5); tick(1); rd_check("R8", A_PEND, 32'h0020);
    src = '0; tick(2); rd_check("R8", A_PEND, 32'h0);

    // R9: routing writes
    wr(A_TRIG, 32'hFFFF);
    for (int i = 0; i < SRC; i++) begin
      wr(A_ROUTE + 10'(i), (32'h1 << (i % 4)) | 32'h0000_0108);
      exp_route[i] = (i % 4 == 3) ? 3 : i % 4;
      rd_check("R9", A_ROUTE + 10'(i), 32'h1 << exp_route[i]);
    end
    wr(A_ROUTE + 10'd0, 32'h0000_0010);
    rd_check("R9", A_ROUTE, 32'h1);

    // R10: priority per context as sources drain
    for (int i = 0; i < SRC; i++) wr(A_WEDGE, 32'h8000_0000 | 32'(i));
    exp_pend = 16'hFFFF; ctx_check("R10");
    for (int k = 0; k < SRC; k++) begin
      wr(A_WEDGE, 32'(k));
      exp_pend[k] = 1'b0; ctx_check("R10");
    end

    // R11: masked pending visible but silent
    for (int i = 0; i < SRC; i++) wr(A_WEDGE, 32'h8000_0000 | 32'(i));
    wr(A_MCLR, 32'hFFFF); exp_mask = '0; exp_pend = 16'hFFFF;
    rd_check("R11", A_PEND, 32'hFFFF);
    ctx_check("R11");
    wr(A_MSET, 32'h0100); exp_mask = 16'h0100;
    ctx_check("R11");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule